// File: doc/BRIEF.md
# Status Byte and Write-Protection Guard

This block owns the status byte of a small serial non-volatile memory and decides, cycle by cycle, whether a modifying command may run. It keeps a volatile write-enable latch and a busy flag, plus three retained bits: two protect-range bits and a status-lock bit. The command decoder in front of it presents one decoded strobe at a time, together with the target address of an array write or the new status byte of a status write. The block answers one cycle later with an array-go, a status-go or a reject pulse.

Every accepted write starts a self-timed cycle. Its length is a parameter counted in system clocks, so a simulation can use a few clocks in place of milliseconds. While the cycle runs, the busy flag is set and every further write is refused. When the cycle ends, a single-cycle done pulse is raised. At the same moment the busy flag drops and the enable latch clears. A pending status write commits its retained bits only at that moment.

The retained bits model non-volatile storage. The synchronous reset does not touch them, and they start at zero. The write-protect pin is active low and passes through a synchroniser before it is used. When the lock bit is set and the pin is low, the status byte is frozen against writes. The order in which the two conditions arise does not matter.

Top module: `nvm_status_guard`

## Requirements
- R1: The status byte `status_q` carries the lock bit in bit 7, zeros in bits 6..4, the upper range bit in bit 3, the lower range bit in bit 2, the enable latch in bit 1 and the busy flag in bit 0.
- R2: While `rst_n` is low at a clock edge, the enable latch and the busy flag clear. Before any status write has committed, the retained bits read 0.
- R3: While the block is idle, a `cmd_wren` strobe sets the enable latch at the next edge, and a `cmd_wrdi` strobe clears it at the next edge.
- R4: An array write or status write issued while the enable latch is 0 raises `cmd_reject` for one cycle and leaves the status byte unchanged.
- R5: After an accepted write, the busy flag reads 1 for exactly CYCLE_CLKS cycles, starting the cycle after the strobe. `cycle_done` pulses for one cycle in the cycle where the busy flag returns to 0, and in that same cycle the enable latch reads 0.
- R6: An array write whose address lies in the protected range is rejected. With an 11-bit address, the range bits select the range as follows: 00 protects nothing, 01 protects 0x600..0x7FF, 10 protects 0x400..0x7FF, and 11 protects every address.
- R7: An accepted status write takes bits 7, 3 and 2 of `sr_wdata` into the lock bit and the two range bits, and ignores the other data bits. The new values are not visible until the cycle that `cycle_done` marks.
- R8: When the lock bit is 1 and the synchronised `wp_n` is low, a status write is rejected even with the enable latch set. The lock holds whichever of the two conditions came first. Driving `wp_n` high, which takes effect two clocks later, lifts it.
- R9: While the busy flag is 1, array and status writes are rejected, and `cmd_wren` and `cmd_wrdi` leave the enable latch unchanged.
- R10: A reset clears the enable latch and the busy flag but keeps the lock bit and both range bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low soft reset |
| wp_n | input | 1 | Write-protect pin, active low, asynchronous |
| cmd_wren | input | 1 | Set-enable-latch strobe |
| cmd_wrdi | input | 1 | Clear-enable-latch strobe |
| cmd_wrsr | input | 1 | Status-write strobe |
| cmd_write | input | 1 | Array-write strobe |
| wr_addr | input | ADDR_W | Target address of an array write |
| sr_wdata | input | 8 | New status byte for a status write |
| status_q | output | 8 | Current status byte |
| arr_go | output | 1 | Array write accepted (one-cycle pulse) |
| sr_go | output | 1 | Status write accepted (one-cycle pulse) |
| cmd_reject | output | 1 | Write refused (one-cycle pulse) |
| cycle_done | output | 1 | Self-timed cycle finished (one-cycle pulse) |

## Verification
The assertions take it for granted that the decoder never raises more than one command strobe in a cycle. They also assume that the strobes are plain single-cycle pulses sampled at the clock. The bench keeps within this contract: each task drives exactly one strobe for one cycle, from the falling clock edge. After each change of `wp_n`, the bench waits several clocks before relying on it, so that the synchroniser has settled.

// File: rtl/sreg_pkg.sv
// Shared types for the status/protection guard.
// Assumes: consumers use these encodings as-is; no behaviour lives here.
package sreg_pkg;
    // retained (non-volatile) status fields
    typedef struct packed {
        logic       lock;
        logic [1:0] rng;
    } nv_bits_t;

    // which kind of write the running timed cycle belongs to
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ARR  = 2'd1,
        OP_SR   = 2'd2
    } pend_op_t;

    localparam int SR_W = 8;
endpackage

// File: rtl/wp_sync.sv
// Synchroniser for the asynchronous write-protect pin.
// Assumes: STAGES >= 2; reset value 0 treats the pin as asserted (conservative).
module wp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic pin_sync
);
    logic [STAGES-1:0] chain_q;

    // shift the raw pin through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], pin_in};
    end

    assign pin_sync = chain_q[STAGES-1];
endmodule

// File: rtl/protect_decode.sv
// Decides whether an address falls inside the range selected by the two range bits.
// Assumes: ADDR_W >= 2; ranges are the top quarter, top half or whole space.
module protect_decode #(
    parameter int ADDR_W = 11
) (
    input  logic [1:0]        rng,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic [1:0] top2;
    assign top2 = addr[ADDR_W-1 -: 2];

    // select the protected slice from the range code
    always_comb begin
        unique case (rng)
            2'b00:   hit = 1'b0;
            2'b01:   hit = (top2 == 2'b11);
            2'b10:   hit = top2[1];
            default: hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/wcycle_timer.sv
// Self-timed write-cycle counter standing in for the programming time.
// Assumes: start arrives only while idle; CYCLE_CLKS >= 1.
module wcycle_timer #(
    parameter int CYCLE_CLKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic fin,
    output logic done_q
);
    localparam int CW = $clog2(CYCLE_CLKS + 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;

    assign fin  = busy_q && (cnt_q == '0);
    assign busy = busy_q;

    // load, count down, and flag completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= fin;
            if (start) begin
                busy_q <= 1'b1;
                cnt_q  <= CW'(CYCLE_CLKS - 1);
            end else if (fin) begin
                busy_q <= 1'b0;
            end else if (busy_q) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q < CW'(CYCLE_CLKS)));

    // R5
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q);
endmodule

// File: rtl/nvm_status_guard.sv
// Status byte holder and write gatekeeper for a serial non-volatile memory.
// Assumes: at most one command strobe per cycle; strobes are single-cycle.
// Retained bits are reset-less and start at zero to model delivery state.
module nvm_status_guard
    import sreg_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int CYCLE_CLKS = 64,
    parameter int SYNC_STG   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_wrsr,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SR_W-1:0]   sr_wdata,
    output logic [SR_W-1:0]   status_q,
    output logic              arr_go,
    output logic              sr_go,
    output logic              cmd_reject,
    output logic              cycle_done
);
    logic     wp_s, hit, wip, fin, start;
    logic     arr_ok, sr_ok, rej, hw_lock;
    logic     wel_q;
    nv_bits_t nv_q = '0;
    nv_bits_t pend_nv_q;
    pend_op_t pend_q;

    wp_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(wp_n), .pin_sync(wp_s)
    );

    protect_decode #(.ADDR_W(ADDR_W)) u_dec (
        .rng(nv_q.rng), .addr(wr_addr), .hit(hit)
    );

    wcycle_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(start),
        .busy(wip), .fin(fin), .done_q(cycle_done)
    );

    // accept/reject decision for the two modifying commands
    always_comb begin
        hw_lock = nv_q.lock && !wp_s;
        arr_ok  = cmd_write && !wip && wel_q && !hit;
        sr_ok   = cmd_wrsr  && !wip && wel_q && !hw_lock;
        start   = arr_ok || sr_ok;
        rej     = (cmd_write || cmd_wrsr) && !start;
    end

    // enable latch: set/clear while idle, drop at cycle end
    always_ff @(posedge clk) begin
        if (!rst_n)                wel_q <= 1'b0;
        else if (fin)              wel_q <= 1'b0;
        else if (!wip && cmd_wren) wel_q <= 1'b1;
        else if (!wip && cmd_wrdi) wel_q <= 1'b0;
    end

    // remember which write is running and its pending status value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= OP_NONE;
            pend_nv_q <= '0;
        end else if (sr_ok) begin
            pend_q    <= OP_SR;
            pend_nv_q <= '{lock: sr_wdata[7], rng: sr_wdata[3:2]};
        end else if (arr_ok) begin
            pend_q    <= OP_ARR;
        end else if (fin) begin
            pend_q    <= OP_NONE;
        end
    end

    // retained bits: commit only when a status cycle completes
    always_ff @(posedge clk) begin
        if (rst_n && fin && pend_q == OP_SR) nv_q <= pend_nv_q;
    end

    // one-cycle response pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_go     <= 1'b0;
            sr_go      <= 1'b0;
            cmd_reject <= 1'b0;
        end else begin
            arr_go     <= arr_ok;
            sr_go      <= sr_ok;
            cmd_reject <= rej;
        end
    end

    assign status_q = {nv_q.lock, 3'b000, nv_q.rng, wel_q, wip};

    // input contract
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_wren, cmd_wrdi, cmd_wrsr, cmd_write}));

    // R3
    wren_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wren && !wip) |=> status_q[1]);

    // R4
    nowel_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_write || cmd_wrsr) && !status_q[1]) |=> cmd_reject);

    // R5
    done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |-> (!status_q[0] && !status_q[1]));

    // R7
    nv_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status_q[7:2]) |-> cycle_done);

    // R9
    busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[0] && (cmd_write || cmd_wrsr)) |=> (cmd_reject && !arr_go && !sr_go));

    // R5
    resp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arr_go, sr_go, cmd_reject}));
endmodule

// File: tb/sim_nvm_status_guard.sv
`timescale 1ns/1ps
module sim_nvm_status_guard;
    localparam int AW  = 11;
    localparam int CYC = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wp_n = 1'b1;
    logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_write = 0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0] sr_wdata = '0;
    logic [7:0] status_q;
    logic arr_go, sr_go, cmd_reject, cycle_done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    nvm_status_guard #(.ADDR_W(AW), .CYCLE_CLKS(CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
        .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
        .cmd_write(cmd_write), .wr_addr(wr_addr), .sr_wdata(sr_wdata),
        .status_q(status_q), .arr_go(arr_go), .sr_go(sr_go),
        .cmd_reject(cmd_reject), .cycle_done(cycle_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // 0 wren, 1 wrdi, 2 wrsr, 3 write; returns at the negedge after the sampling edge
    task automatic strobe(input int kind, input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_addr  = a;
        sr_wdata = d;
        cmd_wren = (kind == 0); cmd_wrdi = (kind == 1);
        cmd_wrsr = (kind == 2); cmd_write = (kind == 3);
        @(negedge clk);
        cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; cmd_write = 0;
    endtask

    task automatic wait_idle();
        while (status_q[0]) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
    endtask

    // commit a status value with the lock open
    task automatic set_sr(input logic [7:0] d);
        strobe(0, '0, '0);
        strobe(2, '0, d);
        wait_idle();
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R2 status after reset", status_q, 8'h00);
        chk("R2 no pulses", {arr_go, sr_go, cmd_reject, cycle_done}, 4'h0);
    endtask

    task automatic t_enable();
        strobe(0, '0, '0);
        chk("R3 wren sets latch", status_q, 8'h02);
        strobe(1, '0, '0);
        chk("R3 wrdi clears latch", status_q, 8'h00);
    endtask

    task automatic t_nowel();
        strobe(3, 11'h010, '0);
        chk("R4 write without latch rejected", {arr_go, cmd_reject}, 2'b01);
        chk("R4 status unchanged", status_q, 8'h00);
        strobe(2, '0, 8'h8C);
        chk("R4 status write without latch rejected", {sr_go, cmd_reject}, 2'b01);
        @(negedge clk);
        chk("R4 reject is one cycle", cmd_reject, 1'b0);
    endtask

    task automatic t_timing();
        int hi = 1;
        strobe(0, '0, '0);
        strobe(3, 11'h020, '0);
        chk("R5 array write accepted", {arr_go, cmd_reject}, 2'b10);
        chk("R5 busy and latch during cycle", status_q[1:0], 2'b11);
        for (int i = 1; i < CYC; i++) begin
            @(negedge clk);
            if (!status_q[0] || cycle_done) hi = 0;
        end
        chk("R5 busy held CYCLE_CLKS cycles", hi, 1);
        @(negedge clk);
        chk("R5 busy/latch clear at end", status_q[1:0], 2'b00);
        chk("R5 done pulse", cycle_done, 1'b1);
        @(negedge clk);
        chk("R5 done one cycle", cycle_done, 1'b0);
    endtask

    task automatic t_ranges();
        logic [AW-1:0] probe [6] = '{11'h000, 11'h3FF, 11'h400, 11'h5FF, 11'h600, 11'h7FF};
        for (int b = 0; b < 4; b++) begin
            set_sr({4'b0000, b[1:0], 2'b00});
            for (int k = 0; k < 6; k++) begin
                logic prot;
                prot = (b == 3) || (b == 2 && probe[k] >= 11'h400) ||
                       (b == 1 && probe[k] >= 11'h600);
                strobe(0, '0, '0);
                strobe(3, probe[k], '0);
                chk($sformatf("R6 range %0d addr %0h", b, probe[k]),
                    {arr_go, cmd_reject}, prot ? 2'b01 : 2'b10);
                if (!prot) wait_idle();
                else strobe(1, '0, '0);
            end
        end
        set_sr(8'h00);
    endtask

    task automatic t_status();
        strobe(0, '0, '0);
        strobe(2, '0, 8'hFF);
        chk("R7 status write accepted", sr_go, 1'b1);
        repeat (CYC / 2) @(negedge clk);
        chk("R7 old value during cycle", status_q, 8'h03);
        wait_idle();
        chk("R7 only lock/range taken (R1 layout)", status_q, 8'h8C);
        set_sr(8'h00);
        chk("R7 cleared again", status_q, 8'h00);
    endtask

    task automatic t_hwlock();
        set_sr(8'h80);
        wp_n = 0; repeat (4) @(negedge clk);
        strobe(0, '0, '0);
        strobe(2, '0, 8'h00);
        chk("R8 locked status write rejected", {sr_go, cmd_reject}, 2'b01);
        chk("R8 status kept, latch kept", status_q, 8'h82);
        wp_n = 1; repeat (4) @(negedge clk);
        strobe(2, '0, 8'h00);
        chk("R8 pin high lifts lock", sr_go, 1'b1);
        wait_idle();
        chk("R8 lock bit cleared", status_q, 8'h00);
        wp_n = 0; repeat (4) @(negedge clk);
        set_sr(8'h80);
        chk("R8 lock set with pin already low", status_q, 8'h80);
        strobe(0, '0, '0);
        strobe(2, '0, 8'h00);
        chk("R8 pin-first order also locks", cmd_reject, 1'b1);
        wp_n = 1; repeat (4) @(negedge clk);
        strobe(1, '0, '0);
        set_sr(8'h00);
    endtask

    task automatic t_busy();
        strobe(0, '0, '0);
        strobe(3, 11'h001, '0);
        strobe(1, '0, '0);
        chk("R9 wrdi ignored while busy", status_q[1:0], 2'b11);
        strobe(3, 11'h002, '0);
        chk("R9 write while busy rejected", {arr_go, cmd_reject}, 2'b01);
        strobe(2, '0, 8'h0C);
        chk("R9 status write while busy rejected", {sr_go, cmd_reject}, 2'b01);
        wait_idle();
        strobe(0, '0, '0);
        strobe(3, 11'h003, '0);
        strobe(0, '0, '0);
        wait_idle();
        chk("R9 wren while busy ignored", status_q, 8'h00);
        chk("R9 rejected status write left no trace", status_q[3:2], 2'b00);
    endtask

    task automatic t_softreset();
        set_sr(8'h88);
        strobe(0, '0, '0);
        chk("R10 latch set before reset", status_q, 8'h8A);
        do_reset();
        chk("R10 reset keeps lock/range, clears latch", status_q, 8'h88);
        strobe(0, '0, '0);
        strobe(3, 11'h100, '0);
        do_reset();
        chk("R10 reset mid-cycle clears busy", status_q, 8'h88);
        set_sr(8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        t_reset();
        t_enable();
        t_nowel();
        t_timing();
        t_ranges();
        t_status();
        t_hwlock();
        t_busy();
        t_softreset();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule